// File: doc/BRIEF.md
# Direct Line Wake-Up and Event Combiner

This block serves the wake-up lines whose interrupt flag is kept inside the peripheral that drives them. It keeps no pending flag and has no interrupt output of its own. Each direct line is brought into the system clock domain and watched for a rising edge. A detected edge on a line that is armed by its wake mask or its event mask is held. The hold ends when the CPU event reset arrives or when both masks of the line are cleared.

The held lines drive three outputs. The first is a CPU event request. It is the OR of every held line whose event mask is set, together with the event request from the configurable-line logic. The second is a CPU wake-up request, registered on the system clock. It covers every held, armed line and the configurable-line wake-up. The third is a system wake-up. It adds any further wake-up sources to the CPU wake-up.

The wake and event masks cover every line, configurable and direct. They sit behind a small word-addressed register port. The full mask vectors are also driven out, so the configurable-line logic can use its own bits.

Top module: `dw_wake_combiner`

## Requirements
- R1: After reset the wake mask reads 0xFFF80000 at address 0 and 0x0000003F at address 2. The event mask reads 0 at addresses 1 and 3.
- R2: Register addresses are: 0 = wake mask of lines 31..0, 1 = event mask of lines 31..0, 2 = wake mask of lines 37..32, 3 = event mask of lines 37..32. At addresses 2 and 3 the line bits sit in data bits 5:0. Data bits 31:6 there read 0, and writes to them are ignored.
- R3: Only a rising edge on a direct line sets a request. A falling edge sets nothing.
- R4: `cpu_evt_o` is high while any held line has its event mask bit at 1, or while `cfg_evt_i` is high.
- R5: `cpu_wake_o` is a registered copy, one clock late, of the OR of `cfg_wake_i` and every held line that has its wake or event mask bit at 1.
- R6: A line whose wake and event mask bits are both 0 has no effect on any output.
- R7: A held request stays asserted after its line falls, until `evt_clr_i` is pulsed. A rising edge detected in the same cycle as the clear is kept.
- R8: Clearing both mask bits of a held line removes its request.
- R9: `sys_wake_o` is high exactly when `cpu_wake_o` or `ext_wake_i` is high, in the same cycle.
- R10: Direct line j maps to mask bit 22+j. A line that rises before a clock edge raises `cpu_evt_o` three clocks later, with two synchronizer stages. `cpu_wake_o` follows one clock after that.
- R11: `wake_mask_o` and `evt_mask_o` always show the current contents of the mask registers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| dir_line_i | input | 16 | Direct wake-up lines, asynchronous |
| cfg_evt_i | input | 1 | Combined CPU event request from the configurable lines |
| cfg_wake_i | input | 1 | Combined wake-up request from the configurable lines |
| ext_wake_i | input | 1 | Other system wake-up sources |
| evt_clr_i | input | 1 | CPU event reset; clears all held requests |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | Register word address |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data (combinational) |
| wake_mask_o | output | 38 | Wake mask of all lines |
| evt_mask_o | output | 38 | Event mask of all lines |
| cpu_evt_o | output | 1 | CPU event request |
| cpu_wake_o | output | 1 | CPU wake-up request, synchronous to clk |
| sys_wake_o | output | 1 | System wake-up request |

## Verification
Some rules are checked by the assertions on every cycle. A held bit may only rise after a detected rising edge. A line with both masks clear holds nothing on the next cycle. The event reset empties every hold when no edge arrives with it. A rise of the CPU wake-up must follow a source one clock earlier. A write to an upper-line register must land in the low data bits only.

Other behaviour can only be shown by the bench's scenarios. These are the exact three- and four-clock latencies, the claim that a falling edge leaves no trace, and hold persistence after the line falls. They also include the reset values and the reserved bits read back through the port. The random mix checks the three outputs against a model of the held set after every step.

// File: rtl/dw_pkg.sv
package dw_pkg;
    typedef enum logic [1:0] {
        SEL_WAKE_LO = 2'd0,
        SEL_EVT_LO  = 2'd1,
        SEL_WAKE_HI = 2'd2,
        SEL_EVT_HI  = 2'd3
    } reg_sel_e;
endpackage

// File: rtl/dw_mask_regs.sv
module dw_mask_regs #(
    parameter int NUM_LINES = 38,
    parameter logic [NUM_LINES-1:0] WAKE_RST = 38'h3F_FFF8_0000
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 we_i,
    input  logic [1:0]           addr_i,
    input  logic [31:0]          wdata_i,
    output logic [31:0]          rdata_o,
    output logic [NUM_LINES-1:0] wake_mask_o,
    output logic [NUM_LINES-1:0] evt_mask_o
);
    localparam int HI_W = NUM_LINES - 32;

    typedef struct packed {
        logic [NUM_LINES-1:0] wake;
        logic [NUM_LINES-1:0] evt;
    } masks_t;

    masks_t m_d, m_q;
    dw_pkg::reg_sel_e sel;

    assign sel = dw_pkg::reg_sel_e'(addr_i);

    always_comb begin
        m_d = m_q;
        if (we_i) begin
            case (sel)
                dw_pkg::SEL_WAKE_LO: m_d.wake[31:0]           = wdata_i;
                dw_pkg::SEL_EVT_LO:  m_d.evt[31:0]            = wdata_i;
                dw_pkg::SEL_WAKE_HI: m_d.wake[NUM_LINES-1:32] = wdata_i[HI_W-1:0];
                default:             m_d.evt[NUM_LINES-1:32]  = wdata_i[HI_W-1:0];
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_q.wake <= WAKE_RST;
            m_q.evt  <= '0;
        end else begin
            m_q <= m_d;
        end
    end

    always_comb begin
        rdata_o = '0;
        case (sel)
            dw_pkg::SEL_WAKE_LO: rdata_o                = m_q.wake[31:0];
            dw_pkg::SEL_EVT_LO:  rdata_o                = m_q.evt[31:0];
            dw_pkg::SEL_WAKE_HI: rdata_o[HI_W-1:0]      = m_q.wake[NUM_LINES-1:32];
            default:             rdata_o[HI_W-1:0]      = m_q.evt[NUM_LINES-1:32];
        endcase
    end

    assign wake_mask_o = m_q.wake;
    assign evt_mask_o  = m_q.evt;

    // R1: reset loads the documented values
    p_rst_vals_r1: assert property (@(posedge clk)
        !rst_n |=> (m_q.wake == WAKE_RST && m_q.evt == '0));

    // R2: an upper-line write lands in the low data bits only
    p_hi_wake_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (we_i && sel == dw_pkg::SEL_WAKE_HI) |=>
            m_q.wake[NUM_LINES-1:32] == $past(wdata_i[HI_W-1:0]));
endmodule

// File: rtl/dw_edge_track.sv
module dw_edge_track #(
    parameter int NUM_DIR     = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_DIR-1:0] line_i,
    input  logic [NUM_DIR-1:0] arm_i,
    input  logic               clr_i,
    output logic [NUM_DIR-1:0] held_o
);
    localparam int LAST = SYNC_STAGES - 1;

    typedef struct packed {
        logic [SYNC_STAGES-1:0][NUM_DIR-1:0] sync;
        logic [NUM_DIR-1:0]                  prev;
        logic [NUM_DIR-1:0]                  held;
    } trk_t;

    trk_t t_d, t_q;
    logic [NUM_DIR-1:0] rise;

    assign rise = t_q.sync[LAST] & ~t_q.prev;

    always_comb begin
        t_d = t_q;
        t_d.sync[0] = line_i;
        for (int k = 1; k < SYNC_STAGES; k++) begin
            t_d.sync[k] = t_q.sync[k-1];
        end
        t_d.prev = t_q.sync[LAST];
        // A fresh edge wins over the clear; a line with no mask holds nothing
        t_d.held = ((t_q.held & {NUM_DIR{~clr_i}}) | rise) & arm_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            t_q <= '0;
        end else begin
            t_q <= t_d;
        end
    end

    assign held_o = t_q.held;

    // R7: the clear empties every hold when no edge arrives with it
    p_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i && rise == '0) |=> t_q.held == '0);

    for (genvar i = 0; i < NUM_DIR; i++) begin : g_chk
        // R3: a hold only starts from a detected rising edge
        p_rise_only_r3: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(t_q.held[i]) |-> $past(rise[i]));
        // R6 / R8: an unarmed line holds nothing on the next cycle
        p_unarmed_r6: assert property (@(posedge clk) disable iff (!rst_n)
            !arm_i[i] |=> !t_q.held[i]);
    end
endmodule

// File: rtl/dw_wake_combiner.sv
module dw_wake_combiner #(
    parameter int NUM_LINES    = 38,
    parameter int FIRST_DIRECT = 22,
    parameter int SYNC_STAGES  = 2,
    parameter logic [NUM_LINES-1:0] WAKE_RST = 38'h3F_FFF8_0000
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic [NUM_LINES-FIRST_DIRECT-1:0] dir_line_i,
    input  logic                           cfg_evt_i,
    input  logic                           cfg_wake_i,
    input  logic                           ext_wake_i,
    input  logic                           evt_clr_i,
    input  logic                           reg_we_i,
    input  logic [1:0]                     reg_addr_i,
    input  logic [31:0]                    reg_wdata_i,
    output logic [31:0]                    reg_rdata_o,
    output logic [NUM_LINES-1:0]           wake_mask_o,
    output logic [NUM_LINES-1:0]           evt_mask_o,
    output logic                           cpu_evt_o,
    output logic                           cpu_wake_o,
    output logic                           sys_wake_o
);
    localparam int NUM_DIR = NUM_LINES - FIRST_DIRECT;

    typedef struct packed {
        logic wake;
    } out_t;

    out_t o_d, o_q;
    logic [NUM_LINES-1:0] wmask, emask;
    logic [NUM_DIR-1:0]   wm_dir, em_dir, arm, held;
    logic                 wake_src;

    dw_mask_regs #(
        .NUM_LINES (NUM_LINES),
        .WAKE_RST  (WAKE_RST)
    ) u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .we_i        (reg_we_i),
        .addr_i      (reg_addr_i),
        .wdata_i     (reg_wdata_i),
        .rdata_o     (reg_rdata_o),
        .wake_mask_o (wmask),
        .evt_mask_o  (emask)
    );

    assign wm_dir = wmask[NUM_LINES-1:FIRST_DIRECT];
    assign em_dir = emask[NUM_LINES-1:FIRST_DIRECT];
    assign arm    = wm_dir | em_dir;

    dw_edge_track #(
        .NUM_DIR     (NUM_DIR),
        .SYNC_STAGES (SYNC_STAGES)
    ) u_edges (
        .clk    (clk),
        .rst_n  (rst_n),
        .line_i (dir_line_i),
        .arm_i  (arm),
        .clr_i  (evt_clr_i),
        .held_o (held)
    );

    assign wake_src = (|(held & arm)) | cfg_wake_i;

    always_comb begin
        o_d      = o_q;
        o_d.wake = wake_src;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            o_q <= '0;
        end else begin
            o_q <= o_d;
        end
    end

    assign cpu_evt_o   = (|(held & em_dir)) | cfg_evt_i;
    assign cpu_wake_o  = o_q.wake;
    assign sys_wake_o  = o_q.wake | ext_wake_i;
    assign wake_mask_o = wmask;
    assign evt_mask_o  = emask;

    // R5: a CPU wake-up only rises after a source was present one clock earlier
    p_wake_source_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cpu_wake_o) |-> $past(cfg_wake_i || (|held)));

    // R4: no event request without an event-masked hold or a configurable event
    p_evt_source_r4: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_evt_o |-> (cfg_evt_i || (|(held & emask[NUM_LINES-1:FIRST_DIRECT]))));
endmodule

// File: tb/sim_dw_wake_combiner.sv
module sim_dw_wake_combiner;
    localparam int CLK_PERIOD = 10;
    localparam int NL = 38;
    localparam int FD = 22;
    localparam int ND = NL - FD;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [ND-1:0] dir_line = '0;
    logic cfg_evt = 1'b0, cfg_wake = 1'b0, ext_wake = 1'b0, evt_clr = 1'b0;
    logic reg_we = 1'b0;
    logic [1:0] reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [NL-1:0] wake_mask, evt_mask;
    logic cpu_evt, cpu_wake, sys_wake;

    int n_tests = 0;
    int n_fail = 0;

    // bench model
    logic [NL-1:0] m_wm, m_em;
    logic [ND-1:0] m_held;

    always #(CLK_PERIOD/2) clk = ~clk;

    dw_wake_combiner u0 (
        .clk(clk), .rst_n(rst_n), .dir_line_i(dir_line),
        .cfg_evt_i(cfg_evt), .cfg_wake_i(cfg_wake), .ext_wake_i(ext_wake),
        .evt_clr_i(evt_clr), .reg_we_i(reg_we), .reg_addr_i(reg_addr),
        .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata),
        .wake_mask_o(wake_mask), .evt_mask_o(evt_mask),
        .cpu_evt_o(cpu_evt), .cpu_wake_o(cpu_wake), .sys_wake_o(sys_wake)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    function automatic logic [ND-1:0] arm_of(input logic [NL-1:0] wm, input logic [NL-1:0] em);
        return wm[NL-1:FD] | em[NL-1:FD];
    endfunction

    function automatic logic exp_evt();
        return (|(m_held & m_em[NL-1:FD])) | cfg_evt;
    endfunction

    function automatic logic exp_wake();
        return (|(m_held & arm_of(m_wm, m_em))) | cfg_wake;
    endfunction

    function automatic logic [31:0] exp_read(input logic [1:0] a);
        case (a)
            2'd0: return m_wm[31:0];
            2'd1: return m_em[31:0];
            2'd2: return {26'd0, m_wm[NL-1:32]};
            default: return {26'd0, m_em[NL-1:32]};
        endcase
    endfunction

    task automatic cycles(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
        case (a)
            2'd0: m_wm[31:0] = d;
            2'd1: m_em[31:0] = d;
            2'd2: m_wm[NL-1:32] = d[5:0];
            default: m_em[NL-1:32] = d[5:0];
        endcase
        m_held &= arm_of(m_wm, m_em);
    endtask

    task automatic rd_chk(input string req, input logic [1:0] a);
        @(negedge clk);
        reg_addr = a;
        #1;
        chk(req, {32'd0, reg_rdata}, {32'd0, exp_read(a)});
    endtask

    task automatic set_lines(input logic [ND-1:0] v);
        @(negedge clk);
        m_held |= (v & ~dir_line) & arm_of(m_wm, m_em);
        dir_line = v;
    endtask

    task automatic pulse_clr();
        @(negedge clk);
        evt_clr = 1'b1;
        @(negedge clk);
        evt_clr = 1'b0;
        m_held = '0;
    endtask

    task automatic chk_outs(input string req);
        chk({req, " evt"},  {63'd0, cpu_evt},  {63'd0, exp_evt()});
        chk({req, " wake"}, {63'd0, cpu_wake}, {63'd0, exp_wake()});
        chk({req, " sys"},  {63'd0, sys_wake}, {63'd0, exp_wake() | ext_wake});
        chk({req, " masks"}, {wake_mask[31:0], evt_mask[31:0]}, {m_wm[31:0], m_em[31:0]});
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'h5EED_1234));
        m_wm = 38'h3F_FFF8_0000;
        m_em = '0;
        m_held = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1 reset values and R11 mirror
        rd_chk("R1 wake lo", 2'd0);
        rd_chk("R1 evt lo", 2'd1);
        rd_chk("R1 wake hi", 2'd2);
        rd_chk("R1 evt hi", 2'd3);
        chk("R11 mask outputs", {26'd0, wake_mask}, {26'd0, 38'h3F_FFF8_0000});
        chk_outs("R1 idle");

        // R2 reserved bits of upper register
        wr(2'd2, 32'hFFFF_FFC5);
        rd_chk("R2 wake hi reserved", 2'd2);
        wr(2'd2, 32'h0000_003F);

        // R10 latency: line 0 (bit 22) with event mask set
        wr(2'd1, 32'h0040_0000);
        @(negedge clk);
        dir_line = 16'h0001;
        m_held = 16'h0001;
        repeat (2) @(posedge clk);
        @(negedge clk);
        chk("R10 evt not before 3", {63'd0, cpu_evt}, 64'd0);
        @(posedge clk); @(negedge clk);
        chk("R10 evt at 3", {63'd0, cpu_evt}, 64'd1);
        chk("R10 wake not at 3", {63'd0, cpu_wake}, 64'd0);
        @(posedge clk); @(negedge clk);
        chk("R10 wake at 4", {63'd0, cpu_wake}, 64'd1);

        // R7 hold persists after the line falls
        set_lines('0);
        cycles(6);
        chk("R7 hold after fall", {63'd0, cpu_evt}, 64'd1);
        pulse_clr();
        cycles(4);
        chk_outs("R7 cleared");

        // R3 falling edge sets nothing
        set_lines(16'h0001);
        cycles(6);
        pulse_clr();
        cycles(3);
        set_lines('0);
        cycles(6);
        chk("R3 fall no evt", {63'd0, cpu_evt}, 64'd0);
        chk("R3 fall no wake", {63'd0, cpu_wake}, 64'd0);

        // R6 unmasked line (line 1, bit 23) has no effect
        wr(2'd0, 32'h0000_0000);
        wr(2'd1, 32'h0000_0000);
        set_lines(16'h0002);
        cycles(6);
        chk("R6 no evt", {63'd0, cpu_evt}, 64'd0);
        chk("R6 no wake", {63'd0, cpu_wake}, 64'd0);
        set_lines('0);

        // R8 clearing the masks drops a held line (line 10 -> bit 32)
        wr(2'd2, 32'h0000_0001);
        set_lines(16'h0400);
        cycles(6);
        chk("R8 held wakes", {63'd0, cpu_wake}, 64'd1);
        chk("R4 wake-only no evt", {63'd0, cpu_evt}, 64'd0);
        wr(2'd2, 32'h0000_0000);
        cycles(3);
        chk("R8 dropped", {63'd0, cpu_wake}, 64'd0);
        set_lines('0);

        // R9 other sources; R4/R5 configurable inputs
        @(negedge clk); ext_wake = 1'b1; #1;
        chk("R9 ext wake", {62'd0, sys_wake, cpu_wake}, 64'd2);
        @(negedge clk); ext_wake = 1'b0; cfg_evt = 1'b1; cfg_wake = 1'b1; #1;
        chk("R4 cfg evt", {63'd0, cpu_evt}, 64'd1);
        cycles(1);
        chk("R5 cfg wake", {63'd0, cpu_wake}, 64'd1);
        @(negedge clk); cfg_evt = 1'b0; cfg_wake = 1'b0;
        cycles(3);

        // random mix
        for (int it = 0; it < 300; it++) begin
            int r;
            r = $urandom % 4;
            case (r)
                0: wr(2'($urandom % 4), $urandom);
                1: set_lines(ND'($urandom));
                2: pulse_clr();
                default: begin
                    @(negedge clk);
                    cfg_evt = 1'($urandom); cfg_wake = 1'($urandom); ext_wake = 1'($urandom);
                end
            endcase
            cycles(6);
            chk_outs("R4 R5 R9 R11 random");
            rd_chk("R2 random read", 2'($urandom % 4));
        end

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule